// File: doc/BRIEF.md
# Thread Interrupt Context Register Window

This block holds the interrupt management state of one hardware thread as a 64-byte context and exposes it through a single memory-mapped slave port. The context is divided into four 16-byte rings: user (bytes 0-15), OS (16-31), pool (32-47) and physical (48-63). Two address bits above the page shift choose one of four privilege views: 0 is hardware (most privileged), 1 is hypervisor, 2 is OS and 3 is user. Each view grants its own per-byte read and write rights.

Address bit 11 splits every page into a plain region and a side-effect region. In the plain region the block first tries a special operation, which is the OS threshold-priority store. If none matches, the access becomes a raw register access whose bytes are filtered by the view's rights. In the side-effect region only a special operation is accepted, which is the OS acknowledge load. A special operation tied to one page may also be invoked from any more privileged page.

A request is presented for one cycle on `req_valid`, and the response appears in the following cycle. The control is a small state machine whose state names the class of the access being answered: ST_IDLE (no response), ST_RAW_RD, ST_RAW_WR, ST_THR_SET, ST_ACK_RD, ST_FAULT_RD and ST_FAULT_WR. On every clock edge the state moves to the class of the request presented in that cycle. With no request it moves to ST_IDLE. Every state can reach every state.

Top module: `irq_ctx_window`

## Requirements
- R1: After reset all context bytes are 0x00, except OS ring bytes 3, 4 and 6 (context bytes 19, 20, 22), which are 0xFF. A hardware-view 8-byte read at offset 0x10 then returns 0x000000FFFF000000.
- R2: Hardware view rights (read/write where granted, none elsewhere), given as ring bytes: user ring 0 and 8-11; OS ring 0-5, 7 and 8-11; pool ring 2, 3 and 8-11; physical ring 0-3, 5, 7, 8, 11 and 12-14.
- R3: The hypervisor view equals the hardware view, except that pool byte 8 and physical bytes 12-14 have no rights. The OS view grants read/write on user ring bytes 0 and 8-11 and on OS ring byte 1. It makes OS ring bytes 0, 2-5 and 7 read-only and grants nothing else. The user view grants read/write on user ring byte 0 only. A read needs the read right and a write needs the write right.
- R4: The byte offset is addr[5:0], and addr[10:6] do not affect a raw access. The access is big-endian: context byte offset+i travels on data lane size-1-i, where lane 0 is bits [7:0]. A byte past 63 has no rights.
- R5: A raw access is rejected with resp_err=1 when its size is below 4, when no lane has the needed right, or when it targets the user ring (addr[5:4]=00). A rejected read returns all 64 bits set. A rejected write changes no byte.
- R6: A raw write stores only the lanes that have the write right. A raw read returns zero on every lane without the read right and on unused upper lanes.
- R7: With addr[11]=1, an access that matches no special operation is an error. As a read it returns all ones.
- R8: A 1-byte write with addr[11:0]=0x011 from view 0, 1 or 2 sets the OS threshold byte (context byte 17) to wdata[7:0] when that value is at most 7, and to 0xFF otherwise, with no error. From view 3 the same access falls through to a raw access and is rejected.
- R9: A 2-byte read with addr[11:0]=0x810 from view 0, 1 or 2 returns 0 with no error and changes nothing. From view 3 it is an error.
- R10: A size other than 1, 2, 4 or 8 bytes is rejected with resp_err=1.
- R11: resp_valid, resp_rdata and resp_err answer a request exactly one cycle after it, and are 0 in a cycle with no response. A write answers with rdata 0. A read issued in the cycle right after a write sees that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+2 | Byte address; top two bits select the view |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Store data, big-endian lanes |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | 64 | Load data |
| resp_err | output | 1 | Access rejected |

## Verification
The store of one access and the response of another can fall in the same cycle. When a read is issued immediately after a write, the write's response is presented while the read samples the context bytes that the write commits at the same edge. The bench provokes this with a directed back-to-back raw write followed by a read of the same bytes. It judges that the write answers with zero data and that the read returns the newly written bytes. The random phase mixes views, sizes, both regions and special offsets against a byte-level model of the context.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int CTX_BYTES  = 64;
    localparam int RING_BYTES = 16;
    localparam int DATA_BYTES = 8;
    localparam int DATA_W     = DATA_BYTES * 8;
    localparam int IDX_W      = $clog2(CTX_BYTES);

    // Ring field positions used by the special operations and reset values
    localparam int OS_RING_BASE = RING_BYTES;
    localparam int FLD_THR      = 1;
    localparam int FLD_LSM      = 3;
    localparam int FLD_ACKCNT   = 4;
    localparam int FLD_AGE      = 6;
    localparam int THR_BYTE     = OS_RING_BASE + FLD_THR;

    localparam logic [11:0] THR_SET_OFS = 12'h011;
    localparam logic [11:0] ACK_OFS     = 12'h810;
    localparam logic [1:0]  OS_PAGE     = 2'd2;
    localparam logic [7:0]  MAX_PRIO    = 8'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAW_RD,
        ST_RAW_WR,
        ST_THR_SET,
        ST_ACK_RD,
        ST_FAULT_RD,
        ST_FAULT_WR
    } win_state_t;

    // Rights code: bit 1 = may read, bit 0 = may write
    function automatic logic [1:0] byte_rights(input logic [1:0] view, input logic [5:0] ofs);
        logic [1:0] ring;
        logic [3:0] b;
        logic       hit;
        ring = ofs[5:4];
        b    = ofs[3:0];
        hit  = 1'b0;
        byte_rights = 2'b00;
        if (view == 2'd0 || view == 2'd1) begin
            unique case (ring)
                2'd0: hit = (b == 4'd0) || (b inside {[4'd8:4'd11]});
                2'd1: hit = (b <= 4'd5) || (b == 4'd7) || (b inside {[4'd8:4'd11]});
                2'd2: hit = (b == 4'd2) || (b == 4'd3) || (b inside {[4'd9:4'd11]}) ||
                            (view == 2'd0 && b == 4'd8);
                default: hit = (b <= 4'd3) || (b == 4'd5) || (b == 4'd7) ||
                               (b == 4'd8) || (b == 4'd11) ||
                               (view == 2'd0 && (b inside {[4'd12:4'd14]}));
            endcase
            byte_rights = hit ? 2'b11 : 2'b00;
        end else if (view == 2'd2) begin
            if (ring == 2'd0) begin
                byte_rights = ((b == 4'd0) || (b inside {[4'd8:4'd11]})) ? 2'b11 : 2'b00;
            end else if (ring == 2'd1) begin
                if (b == 4'd1)
                    byte_rights = 2'b11;
                else if (b <= 4'd5 || b == 4'd7)
                    byte_rights = 2'b10;
            end
        end else begin
            byte_rights = (ring == 2'd0 && b == 4'd0) ? 2'b11 : 2'b00;
        end
    endfunction

    function automatic logic [7:0] ctx_reset_byte(input int k);
        if (k == OS_RING_BASE + FLD_LSM || k == OS_RING_BASE + FLD_ACKCNT ||
            k == OS_RING_BASE + FLD_AGE)
            ctx_reset_byte = 8'hFF;
        else
            ctx_reset_byte = 8'h00;
    endfunction

endpackage

// File: rtl/irq_ctx_lanes.sv
module irq_ctx_lanes
    import irq_ctx_pkg::*;
#(
    parameter int LANES = DATA_BYTES
) (
    input  logic [1:0]                   view,
    input  logic [5:0]                   ofs,
    input  logic [3:0]                   size,
    input  logic                         is_write,
    output logic [LANES-1:0]             lane_en,
    output logic [LANES-1:0][IDX_W-1:0]  lane_idx
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [6:0] pos;
        logic [1:0] code;
        // lane l carries context byte ofs + (size - 1 - l)
        assign pos         = {1'b0, ofs} + {3'b000, size} - 7'(l + 1);
        assign code        = byte_rights(view, pos[5:0]);
        assign lane_idx[l] = pos[IDX_W-1:0];
        assign lane_en[l]  = ({3'b000, size} > 7'(l)) && !pos[6] &&
                             (is_write ? code[0] : code[1]);
    end
endmodule

// File: rtl/irq_ctx_decode.sv
module irq_ctx_decode
    import irq_ctx_pkg::*;
(
    input  logic        valid,
    input  logic        write,
    input  logic [1:0]  view,
    input  logic [11:0] low12,
    input  logic [3:0]  size,
    input  logic        any_lane,
    output win_state_t  kind
);
    logic size_ok;
    logic thr_hit;
    logic ack_hit;
    logic raw_bad;

    always_comb begin
        size_ok = size inside {4'd1, 4'd2, 4'd4, 4'd8};
        thr_hit = write && size == 4'd1 && low12 == THR_SET_OFS && view <= OS_PAGE;
        ack_hit = !write && size == 4'd2 && low12 == ACK_OFS && view <= OS_PAGE;
        raw_bad = (size < 4'd4) || !any_lane || (low12[5:4] == 2'b00);

        if (!valid)
            kind = ST_IDLE;
        else if (!size_ok)
            kind = write ? ST_FAULT_WR : ST_FAULT_RD;
        else if (thr_hit)
            kind = ST_THR_SET;
        else if (ack_hit)
            kind = ST_ACK_RD;
        else if (low12[11] || raw_bad)
            kind = write ? ST_FAULT_WR : ST_FAULT_RD;
        else
            kind = write ? ST_RAW_WR : ST_RAW_RD;
    end
endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store
    import irq_ctx_pkg::*;
#(
    parameter int LANES = DATA_BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [LANES-1:0]             wr_lane_en,
    input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    input  logic [LANES*8-1:0]           wr_data,
    input  logic                         thr_en,
    input  logic [7:0]                   thr_val,
    output logic [LANES-1:0][7:0]        rd_lane,
    output logic [7:0]                   os_thr
);
    logic [7:0] ctx [CTX_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < CTX_BYTES; k++)
                ctx[k] <= ctx_reset_byte(k);
        end else begin
            if (thr_en)
                ctx[THR_BYTE] <= thr_val;
            if (wr_en) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_lane_en[l])
                        ctx[lane_idx[l]] <= wr_data[l*8 +: 8];
                end
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_lane[l] = ctx[lane_idx[l]];
    end

    assign os_thr = ctx[THR_BYTE];
endmodule

// File: rtl/irq_ctx_window.sv
module irq_ctx_window
    import irq_ctx_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = PAGE_SHIFT + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_err
);
    localparam int LANES = DATA_BYTES;

    logic [1:0]                  view;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;
    logic [LANES-1:0][7:0]       rd_lane;
    logic [DATA_W-1:0]           raw_word;
    logic [DATA_W-1:0]           rd_q;
    logic [7:0]                  thr_val;
    logic [7:0]                  os_thr;
    win_state_t                  kind;
    win_state_t                  state_q;

    assign view = req_addr[PAGE_SHIFT +: 2];

    irq_ctx_lanes #(.LANES(LANES)) u_lanes (
        .view     (view),
        .ofs      (req_addr[5:0]),
        .size     (req_size),
        .is_write (req_write),
        .lane_en  (lane_en),
        .lane_idx (lane_idx)
    );

    irq_ctx_decode u_decode (
        .valid    (req_valid),
        .write    (req_write),
        .view     (view),
        .low12    (req_addr[11:0]),
        .size     (req_size),
        .any_lane (|lane_en),
        .kind     (kind)
    );

    assign thr_val = (req_wdata[7:0] > MAX_PRIO) ? 8'hFF : req_wdata[7:0];

    irq_ctx_store #(.LANES(LANES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (kind == ST_RAW_WR),
        .wr_lane_en (lane_en),
        .lane_idx   (lane_idx),
        .wr_data    (req_wdata),
        .thr_en     (kind == ST_THR_SET),
        .thr_val    (thr_val),
        .rd_lane    (rd_lane),
        .os_thr     (os_thr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign raw_word[l*8 +: 8] = lane_en[l] ? rd_lane[l] : 8'h00;
    end

    // State register: the class of the access to be answered next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= kind;
            rd_q    <= (kind == ST_RAW_RD) ? raw_word : '0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        resp_valid = 1'b1;
        resp_err   = 1'b0;
        resp_rdata = '0;
        unique case (state_q)
            ST_IDLE:     resp_valid = 1'b0;
            ST_RAW_RD:   resp_rdata = rd_q;
            ST_RAW_WR:   resp_rdata = '0;
            ST_THR_SET:  resp_rdata = '0;
            ST_ACK_RD:   resp_rdata = '0;
            ST_FAULT_RD: begin
                resp_err   = 1'b1;
                resp_rdata = '1;
            end
            ST_FAULT_WR: resp_err = 1'b1;
            default:     resp_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_ctx_window_chk.sv
module irq_ctx_window_chk
    import irq_ctx_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int ADDR_W     = PAGE_SHIFT + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              resp_err,
    input logic [7:0]        os_thr
);
    logic ack_hit;
    logic thr_hit;
    logic bad_size;

    always_comb begin
        ack_hit  = req_valid && !req_write && req_size == 4'd2 &&
                   req_addr[11:0] == ACK_OFS && req_addr[PAGE_SHIFT +: 2] <= OS_PAGE;
        thr_hit  = req_valid && req_write && req_size == 4'd1 &&
                   req_addr[11:0] == THR_SET_OFS && req_addr[PAGE_SHIFT +: 2] <= OS_PAGE;
        bad_size = !(req_size inside {4'd1, 4'd2, 4'd4, 4'd8});
    end

    p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_err));

    p_write_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> resp_rdata == '0);

    p_fault_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (!resp_err || resp_rdata == '1));

    p_user_ring_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[11] && req_addr[5:4] == 2'b00) |=> resp_err);

    p_special_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11] && !ack_hit) |=> resp_err);

    p_thr_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_hit |=> (!resp_err && (os_thr <= MAX_PRIO || os_thr == 8'hFF)));

    p_ack_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (!resp_err && resp_rdata == '0 && $stable(os_thr)));

    p_bad_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_size) |=> resp_err);
endmodule

bind irq_ctx_window irq_ctx_window_chk #(.PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .resp_err   (resp_err),
    .os_thr     (os_thr)
);

// File: tb/tb_irq_ctx_window.sv
`timescale 1ns/1ps
module tb_irq_ctx_window;
    localparam int PS = 12;
    localparam int AW = PS + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_size = 4'd0;
    logic [63:0]   req_wdata = '0;
    logic          resp_valid;
    logic [63:0]   resp_rdata;
    logic          resp_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [64];

    always #2.5 clk = ~clk;

    irq_ctx_window #(.PAGE_SHIFT(PS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err)
    );

    // Rights from R2/R3 as per-ring 16-bit maps: returns {read, write}
    function automatic logic [1:0] ref_rights(input int view, input int b);
        logic [15:0] rm, wm;
        int ring, bit_n;
        ring = b / 16;
        bit_n = b % 16;
        rm = 16'h0;
        wm = 16'h0;
        case (view)
            0: begin
                case (ring) 0: rm = 16'h0F01; 1: rm = 16'h0FBF; 2: rm = 16'h0F0C; default: rm = 16'h79AF; endcase
                wm = rm;
            end
            1: begin
                case (ring) 0: rm = 16'h0F01; 1: rm = 16'h0FBF; 2: rm = 16'h0E0C; default: rm = 16'h09AF; endcase
                wm = rm;
            end
            2: begin
                if (ring == 0) begin rm = 16'h0F01; wm = 16'h0F01; end
                else if (ring == 1) begin rm = 16'h00BF; wm = 16'h0002; end
            end
            default: if (ring == 0) begin rm = 16'h0001; wm = 16'h0001; end
        endcase
        return {rm[bit_n], wm[bit_n]};
    endfunction

    task automatic predict(input bit wr, input logic [AW-1:0] a, input int sz,
                           input logic [63:0] wd, output logic [63:0] erd,
                           output bit eer, output string tag);
        int view, ofs, low12;
        bit thr, ack, any;
        view  = int'(a[PS +: 2]);
        ofs   = int'(a[5:0]);
        low12 = int'(a[11:0]);
        thr = wr && sz == 1 && low12 == 'h011 && view <= 2;
        ack = !wr && sz == 2 && low12 == 'h810 && view <= 2;
        any = 1'b0;
        for (int i = 0; i < sz && i < 8; i++) begin
            logic [1:0] r;
            if (ofs + i < 64) begin
                r = ref_rights(view, ofs + i);
                if (wr ? r[0] : r[1]) any = 1'b1;
            end
        end
        erd = '0;
        eer = 1'b0;
        if (!(sz == 1 || sz == 2 || sz == 4 || sz == 8)) begin
            eer = 1'b1; tag = "R10";
        end else if (thr) begin
            model[17] = (wd[7:0] > 8'd7) ? 8'hFF : wd[7:0];
            tag = "R8";
        end else if (ack) begin
            tag = "R9";
        end else if (a[11]) begin
            eer = 1'b1; tag = "R7";
        end else if (sz < 4 || !any || a[5:4] == 2'b00) begin
            eer = 1'b1; tag = "R5";
        end else begin
            tag = "R6";
            for (int i = 0; i < sz; i++) begin
                logic [1:0] r;
                int lane;
                lane = sz - 1 - i;
                if (ofs + i < 64) begin
                    r = ref_rights(view, ofs + i);
                    if (wr && r[0]) model[ofs + i] = wd[lane*8 +: 8];
                    if (!wr && r[1]) erd[lane*8 +: 8] = model[ofs + i];
                end
            end
        end
        if (eer && !wr) erd = '1;
    endtask

    task automatic check_resp(input logic [63:0] erd, input bit eer, input string tag);
        checks++;
        if (resp_valid !== 1'b1 || resp_err !== eer || resp_rdata !== erd) begin
            errors++;
            $display("FAIL %s: valid=%0b err=%0b rdata=%h, expected valid=1 err=%0b rdata=%h",
                     tag, resp_valid, resp_err, resp_rdata, eer, erd);
        end
    endtask

    task automatic run_access(input bit wr, input logic [AW-1:0] a, input int sz,
                              input logic [63:0] wd);
        logic [63:0] erd;
        bit eer;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = 4'(sz); req_wdata = wd;
        predict(wr, a, sz, wd, erd, eer, tag);
        @(negedge clk);
        req_valid = 1'b0;
        check_resp(erd, eer, tag);
    endtask

    function automatic logic [AW-1:0] mk(input int view, input int low12);
        return {2'(view), 12'(low12)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] erd_a, erd_b;
        bit eer_a, eer_b;
        string tag_a, tag_b;
        int sizes [8] = '{1, 2, 4, 8, 3, 8, 4, 4};
        void'($urandom(32'h5EED));
        for (int k = 0; k < 64; k++)
            model[k] = (k == 19 || k == 20 || k == 22) ? 8'hFF : 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R1: quiet outputs after reset
        checks++;
        if (resp_valid !== 1'b0 || resp_err !== 1'b0 || resp_rdata !== 64'h0) begin
            errors++;
            $display("FAIL R11: reset outputs valid=%0b err=%0b rdata=%h, expected 0 0 0",
                     resp_valid, resp_err, resp_rdata);
        end

        // R1: reset defaults seen through the hardware and OS views
        checks++;
        predict(1'b0, mk(0, 'h010), 8, 64'h0, erd_a, eer_a, tag_a);
        if (erd_a !== 64'h0000_00FF_FF00_0000) begin
            errors++;
            $display("FAIL R1: model default %h, expected %h", erd_a, 64'h0000_00FF_FF00_0000);
        end
        for (int k = 0; k < 64; k++)
            model[k] = (k == 19 || k == 20 || k == 22) ? 8'hFF : 8'h00;
        run_access(1'b0, mk(0, 'h010), 8, 0);   // R1
        run_access(1'b0, mk(2, 'h010), 8, 0);   // R1, R3
        // R8: threshold store with clamp, from OS, hardware and user views
        run_access(1'b1, mk(2, 'h011), 1, 64'h5);
        run_access(1'b0, mk(0, 'h010), 4, 0);
        run_access(1'b1, mk(2, 'h011), 1, 64'h9);
        run_access(1'b0, mk(1, 'h010), 4, 0);
        run_access(1'b1, mk(0, 'h011), 1, 64'h3);
        run_access(1'b1, mk(3, 'h011), 1, 64'h2);
        run_access(1'b0, mk(0, 'h010), 4, 0);
        // R9 / R7: acknowledge load and side-effect region misses
        run_access(1'b0, mk(2, 'h810), 2, 0);
        run_access(1'b0, mk(0, 'h810), 2, 0);
        run_access(1'b0, mk(3, 'h810), 2, 0);
        run_access(1'b0, mk(2, 'h810), 4, 0);
        run_access(1'b1, mk(1, 'h830), 4, 64'hFFFF_FFFF);
        // R10: illegal size
        run_access(1'b0, mk(0, 'h030), 3, 0);
        // R5: short raw, user ring, no rights; rejected write leaves bytes
        run_access(1'b0, mk(0, 'h030), 2, 0);
        run_access(1'b0, mk(0, 'h000), 4, 0);
        run_access(1'b1, mk(3, 'h000), 4, 64'h1234_5678);
        run_access(1'b0, mk(2, 'h018), 8, 0);
        run_access(1'b1, mk(1, 'h030), 2, 64'hABCD);
        run_access(1'b0, mk(0, 'h030), 4, 0);
        // R6 / R3: OS view writes only the threshold byte of the OS ring
        run_access(1'b1, mk(2, 'h010), 4, 64'hEEEE_EEEE);
        run_access(1'b0, mk(0, 'h010), 8, 0);
        // R4: top of context, aliasing through addr[10:6]
        run_access(1'b1, mk(0, 'h038), 8, 64'h0102_0304_0506_0708);
        run_access(1'b0, mk(0, 'h03C), 8, 0);
        run_access(1'b0, mk(0, 'h7F8), 8, 0);
        run_access(1'b0, mk(1, 'h038), 8, 0);

        // R11: back-to-back write then read of the same bytes
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = mk(0, 'h030); req_size = 4'd4;
        req_wdata = 64'h1122_3344;
        predict(1'b1, req_addr, 4, req_wdata, erd_a, eer_a, tag_a);
        @(negedge clk);
        check_resp(erd_a, eer_a, "R11 write");
        req_write = 1'b0; req_addr = mk(0, 'h030);
        predict(1'b0, req_addr, 4, 0, erd_b, eer_b, tag_b);
        @(negedge clk);
        req_valid = 1'b0;
        check_resp(erd_b, eer_b, "R11 read-after-write");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int v, sel, low, sz;
            bit wr;
            v   = int'($urandom % 4);
            sel = int'($urandom % 8);
            if (sel == 0)      low = 'h011;
            else if (sel == 1) low = 'h810;
            else if (sel == 2) low = 'h800 | int'($urandom % 'h800);
            else               low = int'($urandom % 'h800);
            sz = sizes[$urandom % 8];
            wr = 1'($urandom);
            run_access(wr, mk(v, low), sz, {$urandom, $urandom});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule